// File: doc/BRIEF.md
# Synchronous burst SRAM with cycle decoder

This block is a synthesizable behavioral model of a single-ported synchronous SRAM. It has a two-bit burst address counter. On every rising clock edge it samples three chip selects, two address strobes, a burst-step input and the write controls. It resolves them into one cycle type: idle or deselect, begin burst, next beat, or hold beat. Each non-idle cycle is also marked as a read or a write. The model then performs the array access. The processor-side strobe always starts a read. Writes start through the controller-side strobe, or on later beats of a burst that is already running.

Read data follows a registered access address and appears in the same cycle as the access. The output enable acts without the clock. It gates the bus only while the last cycle was a read. Write data is captured at the clock edge, one byte lane at a time. A sleep input powers the device down two edges after it is raised. The device recovers two edges after the input is lowered. The array keeps its contents while asleep.

Top module: `burst_sram`

## Requirements
- R1: A write is requested when `wr_all_n` is 0, or when `byte_gate_n` is 0 and at least one bit of `byte_en_n` is 0. With `wr_all_n` and `byte_gate_n` both 1, or with the gate low and every byte enable high, a cycle begun by the controller strobe is a read.
- R2: When `cpu_strobe_n` = 0 and `sel_a_n` = 0 on a selected chip, the cycle begins a read burst at `addr`. No array location is written, whatever the write controls are.
- R3: When `ctl_strobe_n` = 0 on a selected chip and a write is requested, the cycle begins a write burst at `addr`. Byte lane b (bits 8b+7..8b) is written when `wr_all_n` = 0. Otherwise it is written only if `byte_gate_n` = 0 and `byte_en_n[b]` = 0.
- R4: The chip is selected only when `sel_a_n` = 0, `sel_b` = 1 and `sel_c_n` = 0. A strobe-started cycle on a deselected chip leaves `rdata_drive` at 0. While `sel_a_n` = 1, `cpu_strobe_n` is ignored: with `ctl_strobe_n` = 1, a running burst continues.
- R5: With both strobes at 1 during a burst, `burst_step_n` = 0 advances the beat counter. With `order_xor` = 0 the low two address bits are (start + beat) mod 4, so a burst wraps after four beats. Reads and writes follow `wr_all_n`, `byte_gate_n` and `byte_en_n` as in R1.
- R6: With `order_xor` = 1 the low two address bits of beat n are start XOR n.
- R7: With both strobes at 1 during a burst, `burst_step_n` = 1 repeats the access at the current address. A later step resumes from there.
- R8: After a deselect or an idle cycle, no burst runs. Step and hold cycles do nothing: they write nothing and leave the bus undriven until a strobe begins a new burst.
- R9: `rdata_drive` = 1 exactly when the last clocked cycle was a read access, `out_en_n` = 0 and the device is awake. `out_en_n` acts without a clock edge. After a write cycle the bus stays undriven even with `out_en_n` = 0.
- R10: If `sleep` is sampled 1 at two consecutive edges, every later edge is ignored until wake-up. During that time nothing is written, the bus is undriven, and the array keeps its contents.
- R11: If `sleep` is sampled 0 at two consecutive edges, the next edge is processed normally. The device wakes with no burst running.
- R12: During and right after reset, `rdata_drive` is 0 and no burst runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_a_n | input | 1 | Chip select A, active low; also gates the processor strobe |
| sel_b | input | 1 | Chip select B, active high |
| sel_c_n | input | 1 | Chip select C, active low |
| cpu_strobe_n | input | 1 | Processor-side address strobe, active low |
| ctl_strobe_n | input | 1 | Controller-side address strobe, active low |
| burst_step_n | input | 1 | Burst step, low advances, high holds |
| wr_all_n | input | 1 | Global write, all lanes, active low |
| byte_gate_n | input | 1 | Byte-write gate, active low |
| byte_en_n | input | NB (2) | Per-lane write enables, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Power-down request, active high |
| order_xor | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr | input | AW (6) | External word address |
| wdata | input | NB*BW (16) | Write data |
| rdata | output | NB*BW (16) | Read data, valid when rdata_drive is 1 |
| rdata_drive | output | 1 | Bus drive enable; 0 means tri-stated |

## Verification
The assertions assume that `order_xor` is held steady across a burst. They also assume that a step or hold cycle is only meaningful after a begin, and that reset is applied long enough to clear the sleep history. The stimulus changes `order_xor` only between bursts. Every burst starts with a strobe, and reset is held for three edges. Reads target only locations written earlier, so an unwritten word never reaches a compared output.

// File: rtl/bsram_pkg.sv
// Shared types for the burst SRAM model.
// Assumes a two-bit burst counter; the beat order is picked per cycle.
package bsram_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_BEGIN = 2'd1,
        CYC_NEXT  = 2'd2,
        CYC_HOLD  = 2'd3
    } cyc_kind_t;

    // Low address bits of a beat, linear or interleaved.
    function automatic logic [1:0] beat_low(input logic [1:0] start,
                                            input logic [1:0] beat,
                                            input logic       xor_order);
        return xor_order ? (start ^ beat) : (start + beat);
    endfunction

endpackage

// File: rtl/bsram_decode.sv
// Cycle decoder: turns sampled pin levels into one cycle kind plus a
// read/write flag and a byte-lane write mask.
// Assumes: down is the registered power-down state, burst_live says a burst runs.
module bsram_decode
    import bsram_pkg::*;
#(
    parameter int NB = 2
) (
    input  logic          sel_a_n,
    input  logic          sel_b,
    input  logic          sel_c_n,
    input  logic          cpu_strobe_n,
    input  logic          ctl_strobe_n,
    input  logic          burst_step_n,
    input  logic          wr_all_n,
    input  logic          byte_gate_n,
    input  logic [NB-1:0] byte_en_n,
    input  logic          down,
    input  logic          burst_live,
    output cyc_kind_t     kind,
    output logic          is_write,
    output logic [NB-1:0] lane_mask
);

    logic chip_on;
    logic wr_req;

    // Priority decode: sleep, processor strobe, controller strobe, burst.
    always_comb begin
        chip_on   = !sel_a_n && sel_b && !sel_c_n;
        wr_req    = !wr_all_n || (!byte_gate_n && (byte_en_n != {NB{1'b1}}));
        lane_mask = !wr_all_n ? {NB{1'b1}} : (!byte_gate_n ? ~byte_en_n : {NB{1'b0}});
        kind      = CYC_IDLE;
        is_write  = 1'b0;
        if (!down) begin
            if (!cpu_strobe_n && !sel_a_n) begin
                if (chip_on) begin
                    kind = CYC_BEGIN;
                end
            end else if (!ctl_strobe_n) begin
                if (chip_on) begin
                    kind     = CYC_BEGIN;
                    is_write = wr_req;
                end
            end else if (burst_live) begin
                kind     = burst_step_n ? CYC_HOLD : CYC_NEXT;
                is_write = wr_req;
            end
        end
    end

endmodule

// File: rtl/bsram_burst.sv
// Burst address unit: holds the start address and beat counter, forms the
// access address of the current cycle and registers it for flow-through reads.
// Assumes order_xor is steady for the length of a burst.
module bsram_burst
    import bsram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cyc_kind_t     kind,
    input  logic          is_write,
    input  logic [AW-1:0] addr_in,
    input  logic          xor_order,
    output logic [AW-1:0] acc_addr,
    output logic [AW-1:0] cur_addr,
    output logic          burst_live,
    output logic          read_live
);

    logic [AW-1:0] base_q;
    logic [1:0]    beat_q;
    logic [1:0]    beat_d;

    // Access address and next beat for this cycle.
    always_comb begin
        beat_d   = beat_q;
        acc_addr = cur_addr;
        case (kind)
            CYC_BEGIN: begin
                beat_d   = 2'd0;
                acc_addr = addr_in;
            end
            CYC_NEXT: begin
                beat_d   = beat_q + 2'd1;
                acc_addr = {base_q[AW-1:2], beat_low(base_q[1:0], beat_d, xor_order)};
            end
            default: begin
            end
        endcase
    end

    // Burst state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q     <= '0;
            beat_q     <= 2'd0;
            cur_addr   <= '0;
            burst_live <= 1'b0;
            read_live  <= 1'b0;
        end else begin
            if (kind == CYC_BEGIN) begin
                base_q <= addr_in;
            end
            beat_q <= beat_d;
            if (kind != CYC_IDLE) begin
                cur_addr <= acc_addr;
            end
            burst_live <= (kind != CYC_IDLE);
            read_live  <= (kind != CYC_IDLE) && !is_write;
        end
    end

    AST_NEXT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CYC_NEXT) |=> (cur_addr[1:0] != $past(cur_addr[1:0])));  // R5
    AST_HOLD_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CYC_HOLD) |=> (cur_addr == $past(cur_addr)));  // R7
    AST_STEP_NEEDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CYC_NEXT || kind == CYC_HOLD) |-> burst_live);  // R8

endmodule

// File: rtl/bsram_sleep.sv
// Power-down sequencer: enters after two consecutive high samples of the
// sleep request and leaves after two consecutive low samples.
// Assumes the request is synchronous to clk.
module bsram_sleep (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep,
    output logic down
);

    logic seen_q;

    // Track the last sample and switch the power state on two agreeing samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            down   <= 1'b0;
        end else begin
            seen_q <= sleep;
            if (seen_q && sleep) begin
                down <= 1'b1;
            end else if (!seen_q && !sleep) begin
                down <= 1'b0;
            end
        end
    end

    AST_ENTRY_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(down) |-> ($past(sleep) && $past(sleep, 2)));  // R10
    AST_EXIT_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(down) |-> (!$past(sleep) && !$past(sleep, 2)));  // R11

endmodule

// File: rtl/bsram_mem.sv
// Storage array split into byte lanes, one array per lane.
// Writes land at the clock edge; the read is combinational.
// Assumes no reset of contents.
module bsram_mem #(
    parameter int AW = 6,
    parameter int NB = 2,
    parameter int BW = 8
) (
    input  logic             clk,
    input  logic             we,
    input  logic [NB-1:0]    lane_mask,
    input  logic [AW-1:0]    waddr,
    input  logic [NB*BW-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [NB*BW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        logic [BW-1:0] lane [DEPTH];

        // Lane write under its own mask bit.
        always_ff @(posedge clk) begin
            if (we && lane_mask[b]) begin
                lane[waddr] <= wdata[b*BW +: BW];
            end
        end

        assign rdata[b*BW +: BW] = lane[raddr];
    end

endmodule

// File: rtl/burst_sram.sv
// Top of the burst SRAM model: decoder, burst unit, sleep sequencer and
// array, plus the bus-drive gating by the asynchronous output enable.
// Assumes synchronous inputs apart from out_en_n.
module burst_sram
    import bsram_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 2,
    parameter int BW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_a_n,
    input  logic             sel_b,
    input  logic             sel_c_n,
    input  logic             cpu_strobe_n,
    input  logic             ctl_strobe_n,
    input  logic             burst_step_n,
    input  logic             wr_all_n,
    input  logic             byte_gate_n,
    input  logic [NB-1:0]    byte_en_n,
    input  logic             out_en_n,
    input  logic             sleep,
    input  logic             order_xor,
    input  logic [AW-1:0]    addr,
    input  logic [NB*BW-1:0] wdata,
    output logic [NB*BW-1:0] rdata,
    output logic             rdata_drive
);

    cyc_kind_t     kind;
    logic          is_write;
    logic [NB-1:0] lane_mask;
    logic          down;
    logic          burst_live;
    logic          read_live;
    logic [AW-1:0] acc_addr;
    logic [AW-1:0] cur_addr;
    logic          mem_we;

    bsram_sleep u_sleep (
        .clk   (clk),
        .rst_n (rst_n),
        .sleep (sleep),
        .down  (down)
    );

    bsram_decode #(.NB(NB)) u_decode (
        .sel_a_n      (sel_a_n),
        .sel_b        (sel_b),
        .sel_c_n      (sel_c_n),
        .cpu_strobe_n (cpu_strobe_n),
        .ctl_strobe_n (ctl_strobe_n),
        .burst_step_n (burst_step_n),
        .wr_all_n     (wr_all_n),
        .byte_gate_n  (byte_gate_n),
        .byte_en_n    (byte_en_n),
        .down         (down),
        .burst_live   (burst_live),
        .kind         (kind),
        .is_write     (is_write),
        .lane_mask    (lane_mask)
    );

    bsram_burst #(.AW(AW)) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .kind       (kind),
        .is_write   (is_write),
        .addr_in    (addr),
        .xor_order  (order_xor),
        .acc_addr   (acc_addr),
        .cur_addr   (cur_addr),
        .burst_live (burst_live),
        .read_live  (read_live)
    );

    // Write strobe for the array: any non-idle write cycle.
    assign mem_we = (kind != CYC_IDLE) && is_write;

    bsram_mem #(.AW(AW), .NB(NB), .BW(BW)) u_mem (
        .clk       (clk),
        .we        (mem_we),
        .lane_mask (lane_mask),
        .waddr     (acc_addr),
        .wdata     (wdata),
        .raddr     (cur_addr),
        .rdata     (rdata)
    );

    // Bus drive: last cycle read, output enabled, device awake.
    assign rdata_drive = read_live && !out_en_n && !down;

    AST_CPU_STROBE_READS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_strobe_n && !sel_a_n) |-> !mem_we);  // R2
    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (((!cpu_strobe_n && !sel_a_n) || !ctl_strobe_n) && (sel_a_n || !sel_b || sel_c_n))
        |=> !rdata_drive);  // R4
    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !rdata_drive);  // R9
    AST_SLEEP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        down |-> !mem_we);  // R10

endmodule

// File: tb/burst_sram_tb.sv
module burst_sram_tb;

    localparam int CLK_P = 10;
    localparam int AW = 6;
    localparam int NB = 2;
    localparam int BW = 8;
    localparam int DW = NB * BW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_a_n, sel_b, sel_c_n;
    logic          cpu_strobe_n, ctl_strobe_n, burst_step_n;
    logic          wr_all_n, byte_gate_n;
    logic [NB-1:0] byte_en_n;
    logic          out_en_n, sleep, order_xor;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic          rdata_drive;

    int n_total = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference state built from the requirements.
    logic [DW-1:0] r_mem [1 << AW];
    logic [AW-1:0] r_base, r_cur;
    logic [1:0]    r_beat;
    logic          r_live, r_rd, r_seen, r_down;

    // Scoreboard queues.
    logic          q_drv [$];
    logic [DW-1:0] q_dat [$];
    string         q_tag [$];

    always #(CLK_P / 2) clk = ~clk;

    burst_sram #(.AW(AW), .NB(NB), .BW(BW)) u_dut (
        .clk(clk), .rst_n(rst_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n), .burst_step_n(burst_step_n),
        .wr_all_n(wr_all_n), .byte_gate_n(byte_gate_n), .byte_en_n(byte_en_n),
        .out_en_n(out_en_n), .sleep(sleep), .order_xor(order_xor), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rdata_drive(rdata_drive)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_pins();
        sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
        cpu_strobe_n = 1'b1; ctl_strobe_n = 1'b1; burst_step_n = 1'b1;
        wr_all_n = 1'b1; byte_gate_n = 1'b1; byte_en_n = '1;
        addr = '0; wdata = '0;
    endtask

    // Driver: model one edge, push the expectation, run the edge.
    task automatic step(input string tag);
        logic          wr;
        logic [NB-1:0] m;
        logic          chip;
        int            kind;
        logic          cwr;
        logic [1:0]    lo;
        wr   = !wr_all_n || (!byte_gate_n && (byte_en_n != '1));
        m    = !wr_all_n ? '1 : (!byte_gate_n ? ~byte_en_n : '0);
        chip = !sel_a_n && sel_b && !sel_c_n;
        kind = 0;
        cwr  = 1'b0;
        if (!r_down) begin
            if (!cpu_strobe_n && !sel_a_n) begin
                if (chip) kind = 1;
            end else if (!ctl_strobe_n) begin
                if (chip) begin kind = 1; cwr = wr; end
            end else if (r_live) begin
                kind = burst_step_n ? 3 : 2;
                cwr  = wr;
            end
        end
        if (kind == 1) begin r_base = addr; r_beat = 2'd0; end
        if (kind == 2) r_beat = r_beat + 2'd1;
        if (kind != 0) begin
            lo    = order_xor ? (r_base[1:0] ^ r_beat) : (r_base[1:0] + r_beat);
            r_cur = {r_base[AW-1:2], lo};
            if (cwr) begin
                for (int b = 0; b < NB; b++) begin
                    if (m[b]) r_mem[r_cur][b*BW +: BW] = wdata[b*BW +: BW];
                end
            end
        end
        r_live = (kind != 0);
        r_rd   = (kind != 0) && !cwr;
        if (r_seen && sleep) r_down = 1'b1;
        else if (!r_seen && !sleep) r_down = 1'b0;
        r_seen = sleep;
        q_drv.push_back(r_rd && !out_en_n && !r_down);
        q_dat.push_back(r_mem[r_cur]);
        q_tag.push_back(tag);
        @(posedge clk);
        @(negedge clk);
    endtask

    // Monitor: compare each edge's outputs away from the edge.
    initial begin
        logic          d;
        logic [DW-1:0] v;
        string         t;
        forever begin
            @(posedge clk);
            #(CLK_P / 4);
            if (q_drv.size() > 0) begin
                d = q_drv.pop_front();
                v = q_dat.pop_front();
                t = q_tag.pop_front();
                check(rdata_drive === d, {t, " drive"}, {31'd0, rdata_drive}, {31'd0, d});
                if (d) check(rdata === v, {t, " data"}, {16'd0, rdata}, {16'd0, v});
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

    initial begin
        idle_pins();
        out_en_n = 1'b0; sleep = 1'b0; order_xor = 1'b0;
        r_base = '0; r_cur = '0; r_beat = 2'd0;
        r_live = 1'b0; r_rd = 1'b0; r_seen = 1'b0; r_down = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rdata_drive === 1'b0, "R12 reset", {31'd0, rdata_drive}, 32'd0);
        rst_n = 1'b1;
        check(rdata_drive === 1'b0, "R12 after reset", {31'd0, rdata_drive}, 32'd0);

        // R3 / R5: controller-started write burst from 9, linear wrap 9,10,11,8.
        ctl_strobe_n = 1'b0; addr = 6'd9; wr_all_n = 1'b0; wdata = 16'h1111;
        step("R3 begin write");
        ctl_strobe_n = 1'b1; burst_step_n = 1'b0;
        wdata = 16'h2222; step("R5 write beat1");
        wdata = 16'h3333; step("R5 write beat2");
        wdata = 16'h4444; step("R5 write beat3");
        burst_step_n = 1'b1; wr_all_n = 1'b1; step("R7 hold read");

        // R2: processor strobe reads although global write is low.
        cpu_strobe_n = 1'b0; addr = 6'd9; wr_all_n = 1'b0; wdata = 16'hDEAD;
        step("R2 cpu strobe read");
        cpu_strobe_n = 1'b1; wr_all_n = 1'b1; burst_step_n = 1'b0;
        step("R5 read beat1");
        step("R5 read beat2");
        step("R5 read beat3");
        step("R5 wrap");
        burst_step_n = 1'b1; step("R7 suspend");
        step("R7 suspend again");
        burst_step_n = 1'b0; step("R7 resume");

        // R6: interleaved order from 9: 9,8,11,10.
        order_xor = 1'b1;
        cpu_strobe_n = 1'b0; burst_step_n = 1'b1; addr = 6'd9; step("R6 begin");
        cpu_strobe_n = 1'b1; burst_step_n = 1'b0;
        step("R6 beat1");
        step("R6 beat2");
        step("R6 beat3");
        idle_pins(); order_xor = 1'b0;

        // R3 / R1: byte-masked writes at 20.
        ctl_strobe_n = 1'b0; addr = 6'd20; wr_all_n = 1'b0; wdata = 16'h5566;
        step("R3 full write");
        wr_all_n = 1'b1; byte_gate_n = 1'b0; byte_en_n = 2'b10; wdata = 16'hABCD;
        step("R3 lane0 write");
        byte_en_n = 2'b01; wdata = 16'h7788;
        step("R3 lane1 write");
        byte_gate_n = 1'b1; byte_en_n = 2'b00; wdata = 16'h0000;
        step("R1 gate high reads");
        byte_gate_n = 1'b0; byte_en_n = 2'b11;
        step("R1 no lane reads");
        idle_pins();

        // R4 / R8: deselected starts and dead bursts.
        ctl_strobe_n = 1'b0; sel_b = 1'b0; addr = 6'd20; wr_all_n = 1'b0; wdata = 16'hFFFF;
        step("R4 sel_b low");
        ctl_strobe_n = 1'b1; burst_step_n = 1'b0;
        step("R8 step after deselect");
        burst_step_n = 1'b1;
        step("R8 hold after deselect");
        sel_b = 1'b1; wr_all_n = 1'b1; cpu_strobe_n = 1'b0; sel_c_n = 1'b1;
        step("R4 sel_c_n high");
        sel_c_n = 1'b0;
        step("R8 contents kept");
        cpu_strobe_n = 1'b0; addr = 6'd9; step("R4 burst start");
        sel_a_n = 1'b1; burst_step_n = 1'b0;
        step("R4 cpu strobe ignored");
        idle_pins();

        // R9: asynchronous output enable and write masking.
        cpu_strobe_n = 1'b0; addr = 6'd9; step("R9 read");
        out_en_n = 1'b1;
        #1 check(rdata_drive === 1'b0, "R9 oe high", {31'd0, rdata_drive}, 32'd0);
        out_en_n = 1'b0;
        #1 check(rdata_drive === 1'b1 && rdata === 16'h1111, "R9 oe low",
                 {15'd0, rdata_drive, rdata}, {15'd0, 1'b1, 16'h1111});
        cpu_strobe_n = 1'b1; ctl_strobe_n = 1'b0; addr = 6'd30; wr_all_n = 1'b0;
        wdata = 16'h3030; step("R9 write undriven");
        idle_pins();
        cpu_strobe_n = 1'b0; addr = 6'd30; step("R9 readback");
        idle_pins();

        // R10 / R11: sleep entry, ignored writes, recovery.
        sleep = 1'b1;
        step("R10 entry edge1");
        step("R10 entry edge2");
        ctl_strobe_n = 1'b0; addr = 6'd30; wr_all_n = 1'b0; wdata = 16'hEEEE;
        step("R10 write ignored");
        step("R10 write ignored again");
        sleep = 1'b0;
        step("R11 exit edge1");
        step("R11 exit edge2");
        idle_pins(); burst_step_n = 1'b0;
        step("R11 no burst after wake");
        idle_pins(); cpu_strobe_n = 1'b0; addr = 6'd30;
        step("R10 contents retained");
        idle_pins();

        @(posedge clk);
        #(CLK_P / 2);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

endmodule